// File: doc/BRIEF.md
# Criticality-Gated Fetch Halt Controller

This block drives the stall line of the fetch unit in an out-of-order core. Its job is to stop new instructions from piling up in the issue queue behind loads that will take a long time. Each load that reaches the issue stage comes with a tag and four flags: the actual L1 miss result, the actual L2 miss result, a predicted-L2-miss flag and a profiling-derived critical bit. A two-bit mode input decides which of these flags make the load a trigger. The choices are any L2 miss, any L1 or L2 miss, or the selective policy, in which only a load that is both predicted to miss and marked critical counts. A fourth code disables halting.

Every triggering load is held in a small table by its tag. Fetch stays halted while any entry is live. An entry is retired when a completion or a wrong-path squash arrives carrying its tag. Events that match no entry change nothing. A saturating counter of halted cycles is provided for observation.

Top module: `fetch_halt_ctrl`

## Requirements
- R1: Mode code 2'b00: an issued load is a trigger exactly when its L2-miss flag is 1.
- R2: Mode code 2'b01: an issued load is a trigger exactly when its L1-miss or L2-miss flag is 1.
- R3: Mode code 2'b10 (selective): an issued load is a trigger exactly when both the predicted-L2-miss flag and the critical bit are 1. The actual miss flags are ignored, so a non-critical missing load never halts fetch.
- R4: Mode code 2'b11: no issued load is a trigger.
- R5: When a trigger is presented at the issue port in cycle t, `fetch_halt` is 1 from cycle t+1 on.
- R6: A completion whose tag matches a tracked entry retires that entry. `fetch_halt` falls one cycle after the event that retires the last live entry, and not before.
- R7: A wrong-path squash whose tag matches a tracked entry retires that entry, with the same timing as R6.
- R8: A completion or squash whose tag matches no tracked entry has no effect on `fetch_halt`.
- R9: Up to DEPTH (default 8) triggering loads are tracked at once. A trigger that arrives while all entries are live is not tracked. Halt is nonetheless held until the table has drained, and the untracked tag's later completion has no effect.
- R10: A change of `mode_sel` affects only loads issued afterwards. Entries already tracked stay live until retired.
- R11: A synchronous active-high `rst` clears every entry, drives `fetch_halt` to 0 and clears `halt_cycles` on the next clock edge. Tags tracked before reset have no effect afterwards.
- R12: `halt_cycles` adds one for every clock edge at which `fetch_halt` is 1, and it saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Halt policy: 00 L2 miss, 01 L1 or L2 miss, 10 selective, 11 off |
| iss_vld | input | 1 | A load reaches the issue stage this cycle |
| iss_tag | input | TAG_W | Tag of the issued load |
| iss_pred_l2 | input | 1 | Load predicted to miss in L2 |
| iss_crit | input | 1 | Load carries the critical annotation |
| iss_l1_miss | input | 1 | Load missed in L1 |
| iss_l2_miss | input | 1 | Load missed in L2 |
| done_vld | input | 1 | A load completes this cycle |
| done_tag | input | TAG_W | Tag of the completing load |
| kill_vld | input | 1 | A wrong-path load is squashed this cycle |
| kill_tag | input | TAG_W | Tag of the squashed load |
| fetch_halt | output | 1 | Stall request to the fetch unit |
| halt_cycles | output | CNT_W | Saturating count of halted cycles |

## Verification
The embedded assertions check on every cycle that a trigger is always followed by halt and that halt never rises without a trigger. They also check that the table gains at most one entry per cycle, that off and selective modes refuse unqualified loads, and that the counter steps or saturates correctly. Only the bench scenarios can show the release behaviour: tag matching on completion and squash, the rejection of foreign tags, the drain after an overflowing trigger, a mode switch with entries still live, and the exact cycle in which halt falls.

// File: rtl/fh_pkg.sv
package fh_pkg;
    typedef enum logic [1:0] {
        FH_L2_ONLY  = 2'b00,
        FH_ANY_MISS = 2'b01,
        FH_SELECT   = 2'b10,
        FH_OFF      = 2'b11
    } fh_mode_e;
endpackage

// File: rtl/fh_trigger_qual.sv
module fh_trigger_qual
    import fh_pkg::*;
(
    input  logic       iss_vld,
    input  logic [1:0] mode_sel,
    input  logic       pred_l2,
    input  logic       crit,
    input  logic       l1_miss,
    input  logic       l2_miss,
    output logic       trig
);
    fh_mode_e mode;
    assign mode = fh_mode_e'(mode_sel);

    always_comb begin
        trig = 1'b0;
        if (iss_vld) begin
            case (mode)
                FH_L2_ONLY:  trig = l2_miss;
                FH_ANY_MISS: trig = l1_miss | l2_miss;
                FH_SELECT:   trig = pred_l2 & crit;
                default:     trig = 1'b0;
            endcase
        end
    end

    // R4: off mode never yields a trigger
    always_comb begin
        a_r4_off_quiet: assert (!(mode == FH_OFF && trig));
    end
    // R3: selective mode rejects loads without the critical bit
    always_comb begin
        a_r3_select_needs_crit: assert (!(mode == FH_SELECT && !crit && trig));
    end
endmodule

// File: rtl/fh_track_table.sv
module fh_track_table #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_vld,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             done_vld,
    input  logic [TAG_W-1:0] done_tag,
    input  logic             kill_vld,
    input  logic [TAG_W-1:0] kill_tag,
    output logic             any_live,
    output logic             full
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]            live;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
    } tbl_t;

    tbl_t             tbl_d, tbl_q;
    logic [DEPTH-1:0] free_mask;
    logic [IDX_W-1:0] free_idx;

    assign free_mask = ~tbl_q.live;

    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_mask[i]) free_idx = IDX_W'(i);
        end
    end

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (tbl_q.live[i] &&
                ((done_vld && tbl_q.tag[i] == done_tag) ||
                 (kill_vld && tbl_q.tag[i] == kill_tag))) begin
                tbl_d.live[i] = 1'b0;
            end
        end
        if (alloc_vld && (|free_mask)) begin
            tbl_d.live[free_idx] = 1'b1;
            tbl_d.tag[free_idx]  = alloc_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tbl_q <= '0;
        else     tbl_q <= tbl_d;
    end

    assign any_live = |tbl_q.live;
    assign full     = &tbl_q.live;

    // R9: at most one entry is added per cycle
    a_r9_one_alloc: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(tbl_q.live) <= $countones($past(tbl_q.live)) + 1));
    // R9: a full table stays full unless something retires
    a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !done_vld && !kill_vld) |=> full);
endmodule

// File: rtl/fh_halt_counter.sv
module fh_halt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (halt && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    a_r12_step: assert property (@(posedge clk) disable iff (rst)
        (halt && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
    a_r12_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/fetch_halt_ctrl.sv
module fetch_halt_ctrl #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             iss_vld,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic             iss_pred_l2,
    input  logic             iss_crit,
    input  logic             iss_l1_miss,
    input  logic             iss_l2_miss,
    input  logic             done_vld,
    input  logic [TAG_W-1:0] done_tag,
    input  logic             kill_vld,
    input  logic [TAG_W-1:0] kill_tag,
    output logic             fetch_halt,
    output logic [CNT_W-1:0] halt_cycles
);
    logic trig;
    logic any_live;
    logic tbl_full;

    fh_trigger_qual u_qual (
        .iss_vld  (iss_vld),
        .mode_sel (mode_sel),
        .pred_l2  (iss_pred_l2),
        .crit     (iss_crit),
        .l1_miss  (iss_l1_miss),
        .l2_miss  (iss_l2_miss),
        .trig     (trig)
    );

    fh_track_table #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .alloc_vld (trig),
        .alloc_tag (iss_tag),
        .done_vld  (done_vld),
        .done_tag  (done_tag),
        .kill_vld  (kill_vld),
        .kill_tag  (kill_tag),
        .any_live  (any_live),
        .full      (tbl_full)
    );

    assign fetch_halt = any_live;

    fh_halt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .halt  (fetch_halt),
        .count (halt_cycles)
    );

    // R5: a trigger halts fetch on the following cycle
    a_r5_halt_next: assert property (@(posedge clk) disable iff (rst)
        trig |=> fetch_halt);
    // R6: halt cannot rise without a trigger
    a_r6_no_spurious_rise: assert property (@(posedge clk) disable iff (rst)
        (!fetch_halt && !trig) |=> !fetch_halt);
    // R9: a full table keeps fetch halted
    a_r9_full_halts: assert property (@(posedge clk) disable iff (rst)
        tbl_full |-> fetch_halt);
    // R11: reset clears halt and counter
    a_r11_reset: assert property (@(posedge clk)
        rst |=> (!fetch_halt && halt_cycles == '0));
endmodule

// File: tb/tb_fetch_halt_ctrl.sv
module tb_fetch_halt_ctrl;
    localparam int TAG_W = 6;
    localparam int CNT_W = 4;
    localparam int CMAX  = 15;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       mode_sel = 2'b00;
    logic             iss_vld = 0, iss_pred_l2 = 0, iss_crit = 0, iss_l1_miss = 0, iss_l2_miss = 0;
    logic [TAG_W-1:0] iss_tag = '0, done_tag = '0, kill_tag = '0;
    logic             done_vld = 0, kill_vld = 0;
    logic             fetch_halt;
    logic [CNT_W-1:0] halt_cycles;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fetch_halt_ctrl #(.DEPTH(8), .TAG_W(TAG_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .iss_vld(iss_vld), .iss_tag(iss_tag), .iss_pred_l2(iss_pred_l2),
        .iss_crit(iss_crit), .iss_l1_miss(iss_l1_miss), .iss_l2_miss(iss_l2_miss),
        .done_vld(done_vld), .done_tag(done_tag),
        .kill_vld(kill_vld), .kill_tag(kill_tag),
        .fetch_halt(fetch_halt), .halt_cycles(halt_cycles)
    );

    // {mode[1:0], pred, crit, l1, l2, expected halt}
    localparam logic [6:0] VEC [14] = '{
        7'b00_0001_1, 7'b00_0010_0, 7'b00_1100_0, 7'b00_0011_1,
        7'b01_0010_1, 7'b01_0001_1, 7'b01_1100_0,
        7'b10_1100_1, 7'b10_1001_0, 7'b10_0111_0, 7'b10_1111_1, 7'b10_0000_0,
        7'b11_1111_0, 7'b11_0001_0
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        logic prev;
        prev = fetch_halt;
        @(posedge clk);
        #1;
        if (prev && exp_cnt < CMAX) exp_cnt++;
        iss_vld = 0; done_vld = 0; kill_vld = 0;
        iss_pred_l2 = 0; iss_crit = 0; iss_l1_miss = 0; iss_l2_miss = 0;
    endtask

    task automatic issue(input logic [TAG_W-1:0] t, input logic [3:0] fl);
        iss_vld = 1; iss_tag = t;
        {iss_pred_l2, iss_crit, iss_l1_miss, iss_l2_miss} = fl;
        step();
    endtask

    task automatic complete(input logic [TAG_W-1:0] t);
        done_vld = 1; done_tag = t; step();
    endtask

    task automatic squash(input logic [TAG_W-1:0] t);
        kill_vld = 1; kill_tag = t; step();
    endtask

    task automatic do_reset();
        rst = 1; step(); step(); rst = 0; exp_cnt = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        #1;
        do_reset();
        check("R11 reset halt", fetch_halt, 0);
        check("R11 reset count", halt_cycles, 0);

        // Mode vectors: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < 14; v++) begin
            string rq;
            case (VEC[v][6:5])
                2'b00: rq = "R1";
                2'b01: rq = "R2";
                2'b10: rq = "R3";
                default: rq = "R4";
            endcase
            mode_sel = VEC[v][6:5];
            issue(6'd5, VEC[v][4:1]);
            check({rq, " trigger/R5 timing"}, fetch_halt, VEC[v][0]);
            complete(6'd5);
            check("R6 release after completion", fetch_halt, 0);
        end
        check("R12 count after vectors", halt_cycles, exp_cnt);

        // R6: two live entries, halt falls only after the last retires
        do_reset();
        mode_sel = 2'b00;
        issue(6'd1, 4'b0001);
        issue(6'd2, 4'b0001);
        complete(6'd1);
        check("R6 one entry still live", fetch_halt, 1);
        complete(6'd2);
        check("R6 last entry retired", fetch_halt, 0);

        // R8 and R7: foreign tags ignored, squash releases
        issue(6'd3, 4'b0001);
        complete(6'd4);
        check("R8 foreign completion ignored", fetch_halt, 1);
        squash(6'd6);
        check("R8 foreign squash ignored", fetch_halt, 1);
        squash(6'd3);
        check("R7 squash releases halt", fetch_halt, 0);
        check("R12 count exact", halt_cycles, exp_cnt);

        // R9: fill table, overflow trigger, drain
        for (int i = 0; i < 8; i++) issue(6'(i), 4'b0001);
        issue(6'd9, 4'b0001);
        for (int i = 0; i < 7; i++) complete(6'(i));
        check("R9 one tracked entry left", fetch_halt, 1);
        complete(6'd9);
        check("R9 untracked tag has no effect", fetch_halt, 1);
        complete(6'd7);
        check("R9 drained table releases", fetch_halt, 0);

        // R10: mode change keeps existing entries, affects new loads only
        mode_sel = 2'b00;
        issue(6'd2, 4'b0001);
        mode_sel = 2'b11;
        step();
        check("R10 entry survives mode change", fetch_halt, 1);
        issue(6'd3, 4'b0001);
        complete(6'd2);
        check("R10 new load under off mode untracked", fetch_halt, 0);

        // R11: reset mid-halt
        mode_sel = 2'b00;
        issue(6'd8, 4'b0001);
        check("R5 halt before reset", fetch_halt, 1);
        do_reset();
        check("R11 reset drops halt", fetch_halt, 0);
        check("R11 reset clears count", halt_cycles, 0);
        complete(6'd8);
        check("R11 old tag gone", fetch_halt, 0);

        // R12: saturation
        issue(6'd1, 4'b0001);
        for (int i = 0; i < 20; i++) step();
        check("R12 saturated count", halt_cycles, CMAX);
        check("R12 model saturated", exp_cnt, CMAX);
        complete(6'd1);
        check("R6 release after long halt", fetch_halt, 0);

        finish_run();
    end
endmodule